// File: doc/BRIEF.md
# Non-maskable interrupt arbiter

This block gathers three non-maskable request sources and hands exactly one request at a time to a processor core. The sources are an external pin and two watchdog overflow strobes. The pin passes through a synchronizer and then an edge detector whose edge is selected by software. Each watchdog strobe only counts as a request when that watchdog's mode field selects interrupt operation. No source can be masked and no source has a programmable priority.

A qualified request sets a pending bit. The block presents the highest eligible pending source on a valid/code pair and holds it there until the core acknowledges it. It then tracks which source is in service. A service of the pin request can be pre-empted, one level deep, by a watchdog. Whether that happens depends on which watchdog fired and on the core's live NMI-in-progress flag. A return-from-interrupt strobe ends the current service. After it, the interrupted pin service resumes, or the block goes idle.

Top module: `nmi_arbiter`

## Requirements
- R1: After reset, `req_valid_o` is 0, `nested_o` is 0 and `req_src_o` is 00. `req_src_o` is 00 whenever no request is presented. Source codes are 01 for the pin, 10 for watchdog 1 and 11 for watchdog 2.
- R2: `edge_mode_i` selects the pin edge: 00 means no detection, 01 rising, 10 falling, 11 both. A selected edge on `pin_i`, applied before a rising clock edge, is presented on the fourth rising edge after it and not on the third.
- R3: If `edge_mode_i` differs from its value on the previous clock in the cycle where a synchronized edge would be detected, that edge is discarded.
- R4: A `wd1_ovf_i` strobe is a request only when `wd1_mode_i` is 2'b10. When accepted while idle, it is presented with code 10 on the second rising edge after the strobe.
- R5: A `wd2_ovf_i` strobe is a request only when `wd2_mode_i` is 2'b01. When accepted while idle, it is presented with code 11 on the second rising edge after the strobe.
- R6: When several sources qualify in the same cycle, only the highest is recorded, in the order watchdog 2 > watchdog 1 > pin. The others are dropped and are never presented.
- R7: A presented request keeps its valid and code until `ack_i` is high. The acknowledge clears that source's pending bit and removes the request on the next edge.
- R8: A repeat request from a source whose pending bit is already set is absorbed and yields only one presentation.
- R9: A pin request that arrives during pin service is held pending, whatever `np_i` is. It is presented on the second edge after `reti_i`.
- R10: A watchdog 1 request during pin service is held while `np_i` is 1. If `np_i` is 0 it is presented at once, and acknowledging it sets `nested_o` to 1.
- R11: A watchdog 2 request during pin service is presented at once, whatever `np_i` is, and acknowledging it sets `nested_o` to 1.
- R12: `reti_i` during a nested service clears `nested_o` and resumes pin service. Otherwise it returns the block to idle. The highest pending source then becomes eligible again.
- R13: During a watchdog service, every new request is held pending until `reti_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 1 | Asynchronous external non-maskable pin |
| edge_mode_i | input | 2 | Pin edge select (00 off, 01 rise, 10 fall, 11 both) |
| wd1_ovf_i | input | 1 | Watchdog 1 overflow strobe |
| wd1_mode_i | input | 2 | Watchdog 1 mode field, 10 enables requests |
| wd2_ovf_i | input | 1 | Watchdog 2 overflow strobe |
| wd2_mode_i | input | 2 | Watchdog 2 mode field, 01 enables requests |
| np_i | input | 1 | Core NMI-in-progress flag |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ack_i | input | 1 | Core acknowledge of the presented request |
| req_valid_o | output | 1 | A request is presented |
| req_src_o | output | 2 | Code of the presented source |
| nested_o | output | 1 | A watchdog service has pre-empted a pin service |

## Verification
The functions that share a cycle are the same-cycle resolution among sources and the pin edge detector. The sweep walks all seven non-empty combinations of pin edge and watchdog strobes. It times the strobes to hit the exact cycle in which the synchronized pin edge is detected. Each combination is judged by the code first presented, and then by the absence of any later request after that one is served. The rule that a mode change discards an edge is provoked the same way, by writing the edge select in the detection cycle.

// File: rtl/nmi_arb_pkg.sv
package nmi_arb_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_PIN  = 2'b01,
    SRC_WD1  = 2'b10,
    SRC_WD2  = 2'b11
  } nmi_src_e;

  localparam int unsigned NUM_SRC = 3;

  // index of each source in pending / winner vectors
  localparam int unsigned IDX_PIN = 0;
  localparam int unsigned IDX_WD1 = 1;
  localparam int unsigned IDX_WD2 = 2;

  localparam logic [1:0] WD1_ARMED = 2'b10;
  localparam logic [1:0] WD2_ARMED = 2'b01;

  function automatic nmi_src_e idx_to_src(input int unsigned idx);
    nmi_src_e s;
    case (idx)
      IDX_PIN: s = SRC_PIN;
      IDX_WD1: s = SRC_WD1;
      IDX_WD2: s = SRC_WD2;
      default: s = SRC_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/nmi_pin_edge.sv
module nmi_pin_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] mode_i,
  output logic       edge_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic [1:0]             mode_q;
  logic                   rise;
  logic                   fall;
  logic                   mode_chg;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        assign sync_d[g] = pin_i;
      end else begin : g_rest
        assign sync_d[g] = sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      mode_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_STAGES-1];
      mode_q <= mode_i;
    end
  end

  always_comb begin
    rise     = sync_q[SYNC_STAGES-1] & ~prev_q;
    fall     = ~sync_q[SYNC_STAGES-1] & prev_q;
    mode_chg = (mode_i != mode_q);
    edge_o   = ~mode_chg & ((rise & mode_i[0]) | (fall & mode_i[1]));
  end

endmodule

// File: rtl/nmi_src_pick.sv
module nmi_src_pick
  import nmi_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin_ev_i,
  input  logic               wd1_ovf_i,
  input  logic [1:0]         wd1_mode_i,
  input  logic               wd2_ovf_i,
  input  logic [1:0]         wd2_mode_i,
  output logic [NUM_SRC-1:0] win_o
);

  logic [NUM_SRC-1:0] raw;

  always_comb begin
    raw          = '0;
    raw[IDX_PIN] = pin_ev_i;
    raw[IDX_WD1] = wd1_ovf_i & (wd1_mode_i == WD1_ARMED);
    raw[IDX_WD2] = wd2_ovf_i & (wd2_mode_i == WD2_ARMED);
    // highest index wins, lower ones dropped
    win_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (raw[i] && (win_o == '0)) win_o[i] = 1'b1;
    end
  end

  p_single_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_o));

  p_winner_from_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_o & ~raw) == '0);

endmodule

// File: rtl/nmi_pend.sv
module nmi_pend
  import nmi_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] pend_d;

  always_comb begin
    // a set while already pending merges into the existing bit
    pend_d = (pend_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  p_set_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/nmi_svc_ctrl.sv
module nmi_svc_ctrl
  import nmi_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               np_i,
  input  logic               reti_i,
  input  logic               ack_i,
  output logic [NUM_SRC-1:0] clr_o,
  output logic               req_valid_o,
  output logic [1:0]         req_src_o,
  output logic               nested_o
);

  logic     req_v_q,  req_v_d;
  nmi_src_e req_s_q,  req_s_d;
  nmi_src_e svc_q,    svc_d;
  nmi_src_e saved_q,  saved_d;
  logic     nested_q, nested_d;

  logic [NUM_SRC-1:0] elig;
  nmi_src_e           pick;
  logic               take;

  // eligibility of pending sources given the service in progress
  always_comb begin
    elig = '0;
    case (svc_q)
      SRC_NONE: elig = '1;
      SRC_PIN: begin
        elig[IDX_WD2] = 1'b1;
        elig[IDX_WD1] = ~np_i;
      end
      default: elig = '0;
    endcase
  end

  always_comb begin
    pick = SRC_NONE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i] && elig[i]) pick = idx_to_src(i);
    end
  end

  assign take = req_v_q & ack_i;

  always_comb begin
    req_v_d  = req_v_q;
    req_s_d  = req_s_q;
    svc_d    = svc_q;
    saved_d  = saved_q;
    nested_d = nested_q;
    clr_o    = '0;

    if (take) begin
      req_v_d = 1'b0;
      req_s_d = SRC_NONE;
      clr_o[int'(req_s_q) - 1] = 1'b1;
    end else if (!req_v_q && (pick != SRC_NONE)) begin
      req_v_d = 1'b1;
      req_s_d = pick;
    end

    if (reti_i) begin
      if (nested_q) begin
        svc_d    = saved_q;
        saved_d  = SRC_NONE;
        nested_d = 1'b0;
      end else begin
        svc_d = SRC_NONE;
      end
    end

    if (take) begin
      if (svc_d != SRC_NONE) begin
        saved_d  = svc_d;
        nested_d = 1'b1;
      end
      svc_d = req_s_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_v_q  <= 1'b0;
      req_s_q  <= SRC_NONE;
      svc_q    <= SRC_NONE;
      saved_q  <= SRC_NONE;
      nested_q <= 1'b0;
    end else begin
      req_v_q  <= req_v_d;
      req_s_q  <= req_s_d;
      svc_q    <= svc_d;
      saved_q  <= saved_d;
      nested_q <= nested_d;
    end
  end

  assign req_valid_o = req_v_q;
  assign req_src_o   = req_v_q ? req_s_q : SRC_NONE;
  assign nested_o    = nested_q;

  p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_v_q && !ack_i) |=> (req_v_q && $stable(req_s_q)));

  p_code_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_v_q |-> (req_s_q != SRC_NONE));

  p_pin_not_reissued_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_q == SRC_PIN) |-> !(req_v_q && (req_s_q == SRC_PIN)));

  p_wd1_blocked_np_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_v_q) && $past(svc_q == SRC_PIN && np_i)) |-> (req_s_q != SRC_WD1));

  p_nest_over_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    nested_q |-> (saved_q == SRC_PIN));

  p_wd_service_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ((svc_q == SRC_WD1 || svc_q == SRC_WD2) && !req_v_q) |=> !req_v_q);

endmodule

// File: rtl/nmi_arbiter.sv
module nmi_arbiter
  import nmi_arb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] edge_mode_i,
  input  logic       wd1_ovf_i,
  input  logic [1:0] wd1_mode_i,
  input  logic       wd2_ovf_i,
  input  logic [1:0] wd2_mode_i,
  input  logic       np_i,
  input  logic       reti_i,
  input  logic       ack_i,
  output logic       req_valid_o,
  output logic [1:0] req_src_o,
  output logic       nested_o
);

  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_int_n;
  logic                  pin_ev;
  logic [NUM_SRC-1:0]    win;
  logic [NUM_SRC-1:0]    pend;
  logic [NUM_SRC-1:0]    clr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[RST_STAGES-1];

  nmi_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_i  (pin_i),
    .mode_i (edge_mode_i),
    .edge_o (pin_ev)
  );

  nmi_src_pick u_pick (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pin_ev_i   (pin_ev),
    .wd1_ovf_i  (wd1_ovf_i),
    .wd1_mode_i (wd1_mode_i),
    .wd2_ovf_i  (wd2_ovf_i),
    .wd2_mode_i (wd2_mode_i),
    .win_o      (win)
  );

  nmi_pend u_pend (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_i  (win),
    .clr_i  (clr),
    .pend_o (pend)
  );

  nmi_svc_ctrl u_svc (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .pend_i      (pend),
    .np_i        (np_i),
    .reti_i      (reti_i),
    .ack_i       (ack_i),
    .clr_o       (clr),
    .req_valid_o (req_valid_o),
    .req_src_o   (req_src_o),
    .nested_o    (nested_o)
  );

endmodule

// File: tb/test_nmi_arbiter.sv
module test_nmi_arbiter;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin_i;
  logic [1:0] edge_mode_i;
  logic       wd1_ovf_i;
  logic [1:0] wd1_mode_i;
  logic       wd2_ovf_i;
  logic [1:0] wd2_mode_i;
  logic       np_i;
  logic       reti_i;
  logic       ack_i;
  logic       req_valid_o;
  logic [1:0] req_src_o;
  logic       nested_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_arbiter i_nmi_arbiter (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .edge_mode_i(edge_mode_i),
    .wd1_ovf_i(wd1_ovf_i), .wd1_mode_i(wd1_mode_i),
    .wd2_ovf_i(wd2_ovf_i), .wd2_mode_i(wd2_mode_i),
    .np_i(np_i), .reti_i(reti_i), .ack_i(ack_i),
    .req_valid_o(req_valid_o), .req_src_o(req_src_o), .nested_o(nested_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ev, input logic [1:0] es, input bit en, input string tag);
    total++;
    if (req_valid_o !== ev || req_src_o !== es || nested_o !== en) begin
      bad++;
      $display("FAIL %s: got v=%0b src=%0d nest=%0b, expected v=%0b src=%0d nest=%0b",
               tag, req_valid_o, req_src_o, nested_o, ev, es, en);
    end
  endtask

  task automatic do_ack();
    ack_i = 1'b1; tick(1); ack_i = 1'b0;
  endtask

  task automatic do_reti();
    reti_i = 1'b1; tick(1); reti_i = 1'b0;
  endtask

  task automatic pulse(input bit w1, input bit w2);
    wd1_ovf_i = w1; wd2_ovf_i = w2; tick(1);
    wd1_ovf_i = 1'b0; wd2_ovf_i = 1'b0;
  endtask

  // serve whatever is presented and return to idle
  task automatic drain();
    if (req_valid_o) do_ack();
    do_reti(); tick(3);
  endtask

  // bring the block into pin service with np as given
  task automatic enter_pin(input bit np);
    np_i = np;
    edge_mode_i = 2'b11; tick(2);
    pin_i = ~pin_i; tick(4);
    chk(1'b1, 2'b01, 1'b0, "R2 pin request before service");
    do_ack();
  endtask

  initial begin
    rst_n = 1'b0; pin_i = 1'b0; edge_mode_i = 2'b00;
    wd1_ovf_i = 1'b0; wd2_ovf_i = 1'b0; wd1_mode_i = 2'b10; wd2_mode_i = 2'b01;
    np_i = 1'b0; reti_i = 1'b0; ack_i = 1'b0;
    tick(3);
    chk(1'b0, 2'b00, 1'b0, "R1 during reset");
    rst_n = 1'b1; tick(5);
    chk(1'b0, 2'b00, 1'b0, "R1 after reset");

    // R2: edge mode sweep, both directions
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 2; d++) begin
        bit expv;
        edge_mode_i = 2'b00; tick(1);
        pin_i = (d == 0) ? 1'b0 : 1'b1; tick(5);
        edge_mode_i = 2'(m); tick(2);
        pin_i = ~pin_i; tick(3);
        chk(1'b0, 2'b00, 1'b0, "R2 not yet on third edge");
        tick(1);
        expv = (d == 0) ? m[0] : m[1];
        chk(expv, expv ? 2'b01 : 2'b00, 1'b0, "R2 edge mode sweep");
        drain();
      end
    end

    // R3: mode change in the detection cycle discards the edge
    edge_mode_i = 2'b01; pin_i = 1'b0; tick(6);
    pin_i = 1'b1; tick(2);
    edge_mode_i = 2'b11; tick(3);
    chk(1'b0, 2'b00, 1'b0, "R3 edge dropped on mode change");
    tick(3);
    chk(1'b0, 2'b00, 1'b0, "R3 no late request");

    // R4 / R5: watchdog mode sweeps
    for (int m = 0; m < 4; m++) begin
      bit e1;
      bit e2;
      wd1_mode_i = 2'(m); pulse(1'b1, 1'b0); tick(1);
      e1 = (m == 2);
      chk(e1, e1 ? 2'b10 : 2'b00, 1'b0, "R4 watchdog 1 mode");
      drain();
      wd2_mode_i = 2'(m); pulse(1'b0, 1'b1); tick(1);
      e2 = (m == 1);
      chk(e2, e2 ? 2'b11 : 2'b00, 1'b0, "R5 watchdog 2 mode");
      drain();
    end
    wd1_mode_i = 2'b10; wd2_mode_i = 2'b01;

    // R6: all same-cycle combinations, strobes aligned to pin detection
    for (int c = 1; c < 8; c++) begin
      logic [1:0] win;
      win = c[2] ? 2'b11 : (c[1] ? 2'b10 : 2'b01);
      edge_mode_i = 2'b11; tick(2);
      if (c[0]) pin_i = ~pin_i;
      tick(2);
      pulse(c[1], c[2]); tick(1);
      chk(1'b1, win, 1'b0, "R6 highest of simultaneous");
      do_ack(); do_reti(); tick(6);
      chk(1'b0, 2'b00, 1'b0, "R6 lower sources dropped");
    end

    // R9: pin during pin service held regardless of np
    for (int n = 0; n < 2; n++) begin
      enter_pin(n[0]);
      pin_i = ~pin_i; tick(6);
      chk(1'b0, 2'b00, 1'b0, "R9 pin held during pin service");
      do_reti(); tick(1);
      chk(1'b1, 2'b01, 1'b0, "R9 pin issued after reti");
      drain();
    end

    // R10 with np=1 and R8 absorption
    enter_pin(1'b1);
    pulse(1'b1, 1'b0); tick(1); pulse(1'b1, 1'b0); tick(3);
    chk(1'b0, 2'b00, 1'b0, "R10 wd1 held while np=1");
    do_reti(); tick(1);
    chk(1'b1, 2'b10, 1'b0, "R12 wd1 issued after reti");
    do_ack(); tick(3);
    chk(1'b0, 2'b00, 1'b0, "R8 repeat absorbed");
    drain();
    chk(1'b0, 2'b00, 1'b0, "R8 no second request");

    // R10 with np=0: pre-emption and nesting
    enter_pin(1'b0);
    pulse(1'b1, 1'b0); tick(1);
    chk(1'b1, 2'b10, 1'b0, "R10 wd1 pre-empts with np=0");
    do_ack();
    chk(1'b0, 2'b00, 1'b1, "R10 nested set");
    do_reti();
    chk(1'b0, 2'b00, 1'b0, "R12 nested cleared on reti");
    np_i = 1'b1; pulse(1'b1, 1'b0); tick(3);
    chk(1'b0, 2'b00, 1'b0, "R12 pin service resumed");
    do_reti(); tick(1);
    chk(1'b1, 2'b10, 1'b0, "R12 held wd1 after final reti");
    drain();

    // R11: wd2 pre-empts regardless of np
    for (int n = 0; n < 2; n++) begin
      enter_pin(n[0]);
      pulse(1'b0, 1'b1); tick(1);
      chk(1'b1, 2'b11, 1'b0, "R11 wd2 pre-empts");
      do_ack();
      chk(1'b0, 2'b00, 1'b1, "R11 nested set");
      do_reti(); do_reti(); tick(3);
      chk(1'b0, 2'b00, 1'b0, "R11 back to idle");
    end

    // R13: during watchdog service everything waits; priority on release
    np_i = 1'b0;
    pulse(1'b0, 1'b1); tick(1);
    chk(1'b1, 2'b11, 1'b0, "R5 wd2 from idle");
    do_ack();
    pulse(1'b1, 1'b0); pulse(1'b0, 1'b1); tick(3);
    chk(1'b0, 2'b00, 1'b0, "R13 held during wd service");
    do_reti(); tick(1);
    chk(1'b1, 2'b11, 1'b0, "R13 wd2 first after reti");
    do_ack(); tick(3);
    chk(1'b0, 2'b00, 1'b0, "R13 wd1 waits behind wd2 service");
    do_reti(); tick(1);
    chk(1'b1, 2'b10, 1'b0, "R13 wd1 after second reti");
    // R7: held until acknowledged
    tick(5);
    chk(1'b1, 2'b10, 1'b0, "R7 request held without ack");
    do_ack();
    chk(1'b0, 2'b00, 1'b0, "R7 cleared by ack");
    do_reti(); tick(3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got running, expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule